// File: doc/BRIEF.md
# Move-Only Processor Bus Fabric

This block is the data-movement core of a processor whose single operation copies one byte-sized value from one place to another. Each 16-bit instruction names where the value goes and where it comes from. The block has a shared data bus and a parameterised set of addressable ports. Every port sits at a fixed 8-bit address. A port that matches the source field of the current instruction places its outgoing value on the bus. A port that matches the destination field captures the bus value at the clock edge.

One kind of port, the immediate port, does not read the bus. It captures the instruction's source field itself, so a constant can be loaded into the machine. The program counter, instruction fetch and the units behind the ports are outside this block. Every port's incoming register is brought out so that those units can read it.

Drivers are combined with a gated OR rather than tri-states. When no port drives, the bus reads zero. When a build deliberately aliases two ports to one address, a conflict flag reports the collision.

Top module: `mvbus_fabric`

## Requirements
- R1: A synchronous active-high `rst` clears every port's incoming and outgoing register to zero on the next rising edge. While no instruction is valid, `bus_data` is zero and `bus_conflict` is low.
- R2: The instruction carries the destination address in bits [15:8] and the source address in bits [7:0]. On a rising edge with `instr_valid` high, every non-immediate port whose address equals the destination loads `bus_data`. Every port whose address differs keeps its incoming register unchanged.
- R3: While `instr_valid` is high, the port whose address equals the source field drives its outgoing register onto `bus_data` in the same cycle, with no register in the path.
- R4: An immediate port that is the destination loads the instruction's source field, zero-extended to the data width, and ignores `bus_data`.
- R5: Each port's outgoing register takes the value of its incoming register one cycle later. An instruction that reads a port in the cycle right after that port was written therefore moves the previous value.
- R6: With `instr_valid` low, no port loads and no port drives. `bus_data` reads zero.
- R7: When the source field matches no port, `bus_data` is zero, so a non-immediate destination loads zero.
- R8: If uniqueness checking is turned off and more than one port matches the source field of a valid instruction, `bus_conflict` is high in that cycle and `bus_data` is the bitwise OR of the drivers. With at most one driver, `bus_conflict` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | The current instruction is to be executed this cycle |
| instr | input | 16 | Move instruction: destination [15:8], source [7:0] |
| bus_data | output | DATA_W | Shared data bus, the OR of all enabled port drivers |
| bus_conflict | output | 1 | More than one port is driving in this cycle |
| port_in_q | output | N_PORTS*DATA_W | Incoming register of every port, port i at bits [i*DATA_W +: DATA_W] |

## Verification
The hardest situation to create from the ports is the read-after-write hazard. A port is used as a source in the cycle right after it was loaded, so its outgoing copy has not caught up yet. The directed stimulus issues that pair of moves back to back and checks that the old value moves. A third move one cycle later must then see the new value. The conflict case cannot occur with unique addresses. A second instance therefore aliases two ports to one address, with the elaboration check switched off.

// File: rtl/mvbus_pkg.sv
package mvbus_pkg;

    localparam int ADDR_W  = 8;
    localparam int INSTR_W = 2 * ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
    } mv_instr_t;

    typedef enum logic {
        PK_REG = 1'b0,
        PK_IMM = 1'b1
    } port_kind_e;

    function automatic logic addr_hit(input logic vld,
                                      input logic [ADDR_W-1:0] field,
                                      input logic [ADDR_W-1:0] mine);
        return vld && (field == mine);
    endfunction

endpackage

// File: rtl/mvbus_port.sv
module mvbus_port
    import mvbus_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADDR  = 8'h10,
    parameter port_kind_e       KIND   = PK_REG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  mv_instr_t         ins,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] in_q,
    output logic [DATA_W-1:0] out_q,
    output logic              drv_en,
    output logic [DATA_W-1:0] drv_val
);

    logic              dst_hit;
    logic [DATA_W-1:0] load_val;

    assign dst_hit = addr_hit(instr_valid, ins.dst, ADDR);
    assign drv_en  = addr_hit(instr_valid, ins.src, ADDR);
    assign drv_val = drv_en ? out_q : '0;

    generate
        if (KIND == PK_IMM) begin : g_imm
            assign load_val = DATA_W'(ins.src);
        end else begin : g_reg
            assign load_val = bus_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            out_q <= '0;
        end else begin
            if (dst_hit) begin
                in_q <= load_val;
            end
            out_q <= in_q;
        end
    end

endmodule

// File: rtl/mvbus_merge.sv
module mvbus_merge #(
    parameter int DATA_W  = 8,
    parameter int N_PORTS = 4
) (
    input  logic [N_PORTS-1:0]        drv_en,
    input  logic [N_PORTS*DATA_W-1:0] drv_val,
    output logic [DATA_W-1:0]         bus,
    output logic                      conflict
);

    localparam int CNT_W = $clog2(N_PORTS + 1);

    logic [CNT_W-1:0] n_drv;

    always_comb begin
        bus   = '0;
        n_drv = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            bus   = bus | drv_val[i*DATA_W +: DATA_W];
            n_drv = n_drv + CNT_W'(drv_en[i]);
        end
    end

    assign conflict = (n_drv > CNT_W'(1));

endmodule

// File: rtl/mvbus_fabric.sv
module mvbus_fabric
    import mvbus_pkg::*;
#(
    parameter int                         DATA_W       = 8,
    parameter int                         N_PORTS      = 4,
    parameter logic [N_PORTS*ADDR_W-1:0]  PORT_ADDRS   = {8'h30, 8'h20, 8'h10, 8'h01},
    parameter logic [N_PORTS-1:0]         IMM_MASK     = 4'b0001,
    parameter bit                         CHECK_UNIQUE = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      instr_valid,
    input  logic [INSTR_W-1:0]        instr,
    output logic [DATA_W-1:0]         bus_data,
    output logic                      bus_conflict,
    output logic [N_PORTS*DATA_W-1:0] port_in_q
);

    mv_instr_t                 ins;
    logic [N_PORTS-1:0]        drv_en;
    logic [N_PORTS*DATA_W-1:0] drv_val;
    logic [N_PORTS*DATA_W-1:0] out_flat;

    assign ins = mv_instr_t'(instr);

    generate
        for (genvar i = 0; i < N_PORTS; i++) begin : g_port
            mvbus_port #(
                .DATA_W (DATA_W),
                .ADDR   (PORT_ADDRS[i*ADDR_W +: ADDR_W]),
                .KIND   (IMM_MASK[i] ? PK_IMM : PK_REG)
            ) u_port (
                .clk         (clk),
                .rst         (rst),
                .instr_valid (instr_valid),
                .ins         (ins),
                .bus_in      (bus_data),
                .in_q        (port_in_q[i*DATA_W +: DATA_W]),
                .out_q       (out_flat[i*DATA_W +: DATA_W]),
                .drv_en      (drv_en[i]),
                .drv_val     (drv_val[i*DATA_W +: DATA_W])
            );
        end

        for (genvar i = 0; i < N_PORTS; i++) begin : g_uniq_a
            for (genvar j = i + 1; j < N_PORTS; j++) begin : g_uniq_b
                if (CHECK_UNIQUE &&
                    PORT_ADDRS[i*ADDR_W +: ADDR_W] == PORT_ADDRS[j*ADDR_W +: ADDR_W]) begin : g_dup
                    $error("mvbus_fabric: ports %0d and %0d share one address", i, j);
                end
            end
        end
    endgenerate

    mvbus_merge #(
        .DATA_W  (DATA_W),
        .N_PORTS (N_PORTS)
    ) u_merge (
        .drv_en   (drv_en),
        .drv_val  (drv_val),
        .bus      (bus_data),
        .conflict (bus_conflict)
    );

endmodule

// File: rtl/mvbus_fabric_chk.sv
module mvbus_fabric_chk
    import mvbus_pkg::*;
#(
    parameter int                        DATA_W     = 8,
    parameter int                        N_PORTS    = 4,
    parameter logic [N_PORTS*ADDR_W-1:0] PORT_ADDRS = {8'h30, 8'h20, 8'h10, 8'h01},
    parameter logic [N_PORTS-1:0]        IMM_MASK   = 4'b0001
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      instr_valid,
    input logic [INSTR_W-1:0]        instr,
    input logic [DATA_W-1:0]         bus_data,
    input logic                      bus_conflict,
    input logic [N_PORTS*DATA_W-1:0] in_flat,
    input logic [N_PORTS*DATA_W-1:0] out_flat,
    input logic [N_PORTS-1:0]        drv_en
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (in_flat == '0) && (out_flat == '0));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> (drv_en == '0) && (bus_data == '0) && !bus_conflict);

    assert_conflict_flag_R8: assert property (@(posedge clk) disable iff (rst)
        !$onehot0(drv_en) |-> bus_conflict);

    assert_no_false_conflict_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_en) |-> !bus_conflict);

    assert_empty_bus_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (drv_en == '0) |-> (bus_data == '0));

    generate
        for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
            localparam logic [ADDR_W-1:0] A = PORT_ADDRS[i*ADDR_W +: ADDR_W];

            assert_hold_when_unaddressed_R2: assert property (@(posedge clk) disable iff (rst)
                !(instr_valid && instr[15:8] == A) |=> $stable(in_flat[i*DATA_W +: DATA_W]));

            assert_source_drives_R3: assert property (@(posedge clk) disable iff (rst)
                (drv_en[i] && $onehot0(drv_en)) |-> bus_data == out_flat[i*DATA_W +: DATA_W]);

            assert_out_follows_in_R5: assert property (@(posedge clk) disable iff (rst)
                !rst |=> out_flat[i*DATA_W +: DATA_W] == $past(in_flat[i*DATA_W +: DATA_W]));

            if (IMM_MASK[i]) begin : g_imm
                assert_imm_loads_src_R4: assert property (@(posedge clk) disable iff (rst)
                    (instr_valid && instr[15:8] == A) |=>
                        in_flat[i*DATA_W +: DATA_W] == DATA_W'($past(instr[7:0])));
            end else begin : g_reg
                assert_reg_loads_bus_R2: assert property (@(posedge clk) disable iff (rst)
                    (instr_valid && instr[15:8] == A) |=>
                        in_flat[i*DATA_W +: DATA_W] == $past(bus_data));
            end
        end
    endgenerate

endmodule

bind mvbus_fabric mvbus_fabric_chk #(
    .DATA_W     (DATA_W),
    .N_PORTS    (N_PORTS),
    .PORT_ADDRS (PORT_ADDRS),
    .IMM_MASK   (IMM_MASK)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .instr_valid  (instr_valid),
    .instr        (instr),
    .bus_data     (bus_data),
    .bus_conflict (bus_conflict),
    .in_flat      (port_in_q),
    .out_flat     (out_flat),
    .drv_en       (drv_en)
);

// File: tb/mvbus_fabric_tb.sv
module mvbus_fabric_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [7:0]  bus_data;
    logic        bus_conflict;
    logic [31:0] port_in_q;

    logic        a_valid = 1'b0;
    logic [15:0] a_instr = 16'h0000;
    logic [7:0]  a_bus;
    logic        a_conflict;
    logic [23:0] a_in_q;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [7:0] bus_seen;
    logic       err_seen;

    always #4 clk = ~clk;

    mvbus_fabric u_dut (
        .clk          (clk),
        .rst          (rst),
        .instr_valid  (instr_valid),
        .instr        (instr),
        .bus_data     (bus_data),
        .bus_conflict (bus_conflict),
        .port_in_q    (port_in_q)
    );

    mvbus_fabric #(
        .DATA_W       (8),
        .N_PORTS      (3),
        .PORT_ADDRS   ({8'h40, 8'h40, 8'h01}),
        .IMM_MASK     (3'b001),
        .CHECK_UNIQUE (1'b0)
    ) u_alias (
        .clk          (clk),
        .rst          (rst),
        .instr_valid  (a_valid),
        .instr        (a_instr),
        .bus_data     (a_bus),
        .bus_conflict (a_conflict),
        .port_in_q    (a_in_q)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pin(input int i);
        return port_in_q[i*8 +: 8];
    endfunction

    // Called at a falling edge; drives one cycle, records the bus, returns at the next falling edge.
    task automatic step(input logic v, input logic [7:0] dst, input logic [7:0] src);
        instr_valid = v;
        instr       = {dst, src};
        #1;
        bus_seen = bus_data;
        err_seen = bus_conflict;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic astep(input logic v, input logic [7:0] dst, input logic [7:0] src);
        a_valid = v;
        a_instr = {dst, src};
        #1;
        bus_seen = a_bus;
        err_seen = a_conflict;
        @(negedge clk);
        a_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "inbound regs after reset", port_in_q, 32'h0);
        check("R1", "bus idle after reset", bus_data, 8'h00);
        check("R1", "conflict idle after reset", bus_conflict, 1'b0);
    endtask

    task automatic t_immediate();
        step(1'b1, 8'h01, 8'h5A);
        check("R7", "bus with unmatched source 0x5A", bus_seen, 8'h00);
        check("R4", "immediate port loads source field", pin(0), 8'h5A);
        check("R2", "other ports untouched", port_in_q[31:8], 24'h0);
    endtask

    task automatic t_invalid();
        step(1'b0, 8'h10, 8'h01);
        check("R6", "no drive while invalid", bus_seen, 8'h00);
        check("R6", "no load while invalid", pin(1), 8'h00);
    endtask

    task automatic t_move();
        step(1'b1, 8'h10, 8'h01);
        check("R3", "source port drives bus", bus_seen, 8'h5A);
        check("R2", "destination loads bus", pin(1), 8'h5A);
    endtask

    task automatic t_hazard();
        step(1'b1, 8'h20, 8'h10);
        check("R5", "read right after write moves old value", bus_seen, 8'h00);
        check("R5", "destination gets old value", pin(2), 8'h00);
        step(1'b1, 8'h30, 8'h10);
        check("R5", "one cycle later the new value moves", bus_seen, 8'h5A);
        check("R5", "destination gets new value", pin(3), 8'h5A);
    endtask

    task automatic t_unmatched();
        step(1'b1, 8'h01, 8'hC3);
        step(1'b0, 8'h00, 8'h00);
        step(1'b1, 8'h20, 8'h01);
        check("R2", "chained move into port 2", pin(2), 8'hC3);
        step(1'b0, 8'h00, 8'h00);
        step(1'b1, 8'h20, 8'h99);
        check("R7", "bus with unmatched source 0x99", bus_seen, 8'h00);
        check("R7", "destination loads zero", pin(2), 8'h00);
        check("R2", "bystander port 3 unchanged", pin(3), 8'h5A);
        check("R2", "bystander port 1 unchanged", pin(1), 8'h5A);
    endtask

    task automatic t_self();
        step(1'b1, 8'h30, 8'h30);
        check("R3", "self move drives bus", bus_seen, 8'h5A);
        check("R2", "self move keeps value", pin(3), 8'h5A);
    endtask

    task automatic t_midreset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "reset mid-run clears ports", port_in_q, 32'h0);
        step(1'b1, 8'h10, 8'h30);
        check("R1", "outbound cleared by reset", bus_seen, 8'h00);
    endtask

    task automatic t_alias();
        astep(1'b1, 8'h01, 8'h3C);
        astep(1'b0, 8'h00, 8'h00);
        astep(1'b1, 8'h40, 8'h01);
        check("R8", "single driver: no conflict", err_seen, 1'b0);
        check("R2", "both aliased ports load", a_in_q[23:8], 16'h3C3C);
        astep(1'b0, 8'h00, 8'h00);
        astep(1'b1, 8'h01, 8'h40);
        check("R8", "two drivers raise conflict", err_seen, 1'b1);
        check("R8", "bus is OR of drivers", bus_seen, 8'h3C);
        check("R4", "immediate ignores bus, takes field", a_in_q[7:0], 8'h40);
        astep(1'b0, 8'h00, 8'h00);
        check("R6", "conflict gone when idle", bus_seen == 8'h00 && !err_seen, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_immediate();
        t_invalid();
        t_move();
        t_hazard();
        t_unmatched();
        t_self();
        t_midreset();
        t_alias();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule